// File: doc/BRIEF.md
# Binary Floating-Point Adder

This block adds two IEEE 754 binary floating-point operands. The default format is binary32, and the exponent and fraction widths are parameters. Each operand is sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. Pairs that involve a NaN, an infinity or a zero are settled by a priority network before any arithmetic is done. All remaining pairs go through a datapath that works in three steps:

- Subnormal significands are normalized and the significands are extended by three low-order bits: guard, round and sticky.
- The smaller operand is aligned with a sticky-preserving right shift. The magnitudes are then added or subtracted.
- The result is renormalized and rounded in one of four modes.

To subtract, the caller flips the sign bit of the second operand. A flush control treats subnormal inputs as zeros of the same sign. The result and four exception flags are registered, so they appear one clock after the operands are presented. A new pair may be presented every cycle.

Top module: `fpadd_sp`

## Requirements
- R1: When `flush_dnorm` is 1, an input with a zero exponent field and a nonzero fraction is treated as a zero of its own sign. When `flush_dnorm` is 0, that input is added at its true value.
- R2: A signalling NaN has an all-ones exponent, a nonzero fraction and fraction MSB 0. If `op_a` is a signalling NaN, the result is `op_a` with its fraction MSB set, and invalid is raised. If only `op_b` is a signalling NaN, the result is `op_b` quieted the same way, with invalid raised.
- R3: When neither operand is signalling, a quiet NaN passes through unchanged with no flags. A quiet NaN in `op_a` wins over one in `op_b`.
- R4: Infinities of equal sign give that infinity. Infinities of opposite sign give the default NaN and raise invalid. The default NaN has sign 0, an all-ones exponent and only the fraction MSB set (0x7FC00000 for binary32). An infinity plus any finite value returns the infinity. Invalid is never raised together with any other flag.
- R5: Two zeros of equal sign give that zero. Two zeros of opposite sign give +0, or -0 in mode 3. A zero plus a nonzero finite operand returns the other operand bit for bit.
- R6: For finite nonzero operands, the result is the exact sum rounded in the mode on `round_mode`. The encodings are: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R7: When the exact sum of two nonzero finite operands is zero, the result is +0. In mode 3 it is -0. No flags are raised.
- R8: Inexact is raised whenever the rounded result differs from the exact sum.
- R9: When the rounded exponent would reach the all-ones code, overflow and inexact are raised. The result is infinity in mode 0, in mode 2 for a positive sum and in mode 3 for a negative sum. Otherwise the result is the largest finite value of the result's sign.
- R10: Underflow is raised only for a tiny result that is also inexact. Sums of finite operands that land in the subnormal range are exact, so they come out as subnormals with no flags.
- R11: Result and flags are registered. They reflect the operands one rising clock edge later. While `rst_n` is low they are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 1+EXP_W+MAN_W | First operand |
| op_b | input | 1+EXP_W+MAN_W | Second operand |
| round_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| flush_dnorm | input | 1 | Treat subnormal inputs as signed zeros |
| sum_q | output | 1+EXP_W+MAN_W | Registered rounded sum |
| invalid_q | output | 1 | Invalid operation flag |
| overflow_q | output | 1 | Overflow flag |
| underflow_q | output | 1 | Underflow flag |
| inexact_q | output | 1 | Inexact flag |

## Verification
The bound checker watches several rules on every cycle:

- A signalling NaN at either input always raises invalid one cycle later.
- Any NaN that leaves the block is quiet.
- Invalid never appears together with another flag.
- Overflow always comes with inexact.
- An exact cancellation inside the datapath yields a zero whose sign follows the rounding mode.
- Underflow never rises.

Whether the rounded value itself is right, the priority between two NaNs, and the handling of subnormals with and without flushing can only be shown by the bench. The bench sweeps every operand pair of a reduced 8-bit format (4 exponent bits, 3 fraction bits) across all modes. It compares each result against an exact integer sum rounded by its own model, and it also runs directed ties, carries and overflows.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;

  typedef enum logic [2:0] {
    CL_ZERO  = 3'd0,
    CL_DNORM = 3'd1,
    CL_NORM  = 3'd2,
    CL_INF   = 3'd3,
    CL_QNAN  = 3'd4,
    CL_SNAN  = 3'd5
  } fp_class_e;

  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_ZERO = 2'd1;
  localparam logic [1:0] RM_POS  = 2'd2;
  localparam logic [1:0] RM_NEG  = 2'd3;

endpackage

// File: rtl/fpadd_lzc.sv
`timescale 1ns/1ps
module fpadd_lzc #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] count
);
  logic found;

  always_comb begin
    count = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!found) begin
        if (vec[i]) found = 1'b1;
        else        count = count + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fpadd_sticky_shr.sv
`timescale 1ns/1ps
module fpadd_sticky_shr #(
  parameter int N  = 27,
  parameter int AW = 12
) (
  input  logic [N-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [N-1:0]  dout
);
  logic [N-1:0] acc;
  logic         lost;

  always_comb begin
    acc  = din;
    lost = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (i < int'(amt)) begin
        lost = lost | acc[0];
        acc  = acc >> 1;
      end
    end
    dout = {acc[N-1:1], acc[0] | lost};
  end
endmodule

// File: rtl/fpadd_unpack.sv
`timescale 1ns/1ps
module fpadd_unpack import fpadd_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int XE_W  = 12
) (
  input  logic [EXP_W+MAN_W:0]   op,
  input  logic                   flush,
  output fp_class_e              cls,
  output logic                   sign,
  output logic signed [XE_W-1:0] exp_u,
  output logic [MAN_W:0]         sig
);
  localparam int SIG_W = MAN_W + 1;
  localparam int LZ_W  = $clog2(MAN_W + 1);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac;
  logic [LZ_W-1:0]  lz;
  logic             exp_ones, exp_zero, frac_zero;

  assign sign      = op[EXP_W+MAN_W];
  assign exp_f     = op[EXP_W+MAN_W-1:MAN_W];
  assign frac      = op[MAN_W-1:0];
  assign exp_ones  = &exp_f;
  assign exp_zero  = ~|exp_f;
  assign frac_zero = ~|frac;

  fpadd_lzc #(.N(MAN_W), .CW(LZ_W)) u_lzc (.vec(frac), .count(lz));

  always_comb begin
    if (exp_ones)                  cls = frac_zero ? CL_INF : (frac[MAN_W-1] ? CL_QNAN : CL_SNAN);
    else if (exp_zero && (frac_zero || flush)) cls = CL_ZERO;
    else if (exp_zero)             cls = CL_DNORM;
    else                           cls = CL_NORM;
  end

  // a subnormal is shifted until its leading one lands in the hidden position
  always_comb begin
    if (exp_zero) begin
      sig   = SIG_W'({1'b0, frac} << (lz + LZ_W'(1)));
      exp_u = XE_W'(0) - XE_W'(lz);
    end else begin
      sig   = {1'b1, frac};
      exp_u = XE_W'(exp_f);
    end
  end
endmodule

// File: rtl/fpadd_special.sv
`timescale 1ns/1ps
module fpadd_special import fpadd_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  fp_class_e            cls_x,
  input  fp_class_e            cls_y,
  input  logic [EXP_W+MAN_W:0] op_x,
  input  logic [EXP_W+MAN_W:0] op_y,
  input  logic [1:0]           rmode,
  output logic                 hit,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 invalid
);
  localparam int W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] QMASK   = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic sx, sy;
  assign sx = op_x[W-1];
  assign sy = op_y[W-1];

  always_comb begin
    hit     = 1'b1;
    invalid = 1'b0;
    result  = op_x;
    if (cls_x == CL_SNAN) begin
      result  = op_x | QMASK;
      invalid = 1'b1;
    end else if (cls_y == CL_SNAN) begin
      result  = op_y | QMASK;
      invalid = 1'b1;
    end else if (cls_x == CL_QNAN) begin
      result = op_x;
    end else if (cls_y == CL_QNAN) begin
      result = op_y;
    end else if (cls_x == CL_INF && cls_y == CL_INF) begin
      if (sx == sy) result = op_x;
      else begin
        result  = DEF_NAN;
        invalid = 1'b1;
      end
    end else if (cls_x == CL_INF) begin
      result = op_x;
    end else if (cls_y == CL_INF) begin
      result = op_y;
    end else if (cls_x == CL_ZERO && cls_y == CL_ZERO) begin
      result = {(sx == sy) ? sx : (rmode == RM_NEG), {(W-1){1'b0}}};
    end else if (cls_x == CL_ZERO) begin
      result = op_y;
    end else if (cls_y == CL_ZERO) begin
      result = op_x;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/fpadd_align_add.sv
`timescale 1ns/1ps
module fpadd_align_add #(
  parameter int MAN_W = 23,
  parameter int XE_W  = 12
) (
  input  logic                   sx,
  input  logic signed [XE_W-1:0] ex,
  input  logic [MAN_W:0]         mx,
  input  logic                   sy,
  input  logic signed [XE_W-1:0] ey,
  input  logic [MAN_W:0]         my,
  output logic                   s_out,
  output logic signed [XE_W-1:0] e_out,
  output logic [MAN_W+3:0]       m_out,
  output logic                   zero_out
);
  localparam int SIG_W = MAN_W + 1;
  localparam int EXT_W = SIG_W + 3;
  localparam int LZ_W  = $clog2(EXT_W + 1);

  logic                   x_big, sa, sb, carry;
  logic signed [XE_W-1:0] ea, eb;
  logic [SIG_W-1:0]       ma, mb;
  logic [EXT_W-1:0]       ma_e, mb_e, mb_al, dif;
  logic [EXT_W:0]         tot;
  logic [XE_W-1:0]        amt;
  logic [LZ_W-1:0]        lzn;

  // the operand of larger magnitude becomes a
  assign x_big = (ex > ey) || ((ex == ey) && (mx >= my));
  assign sa = x_big ? sx : sy;
  assign sb = x_big ? sy : sx;
  assign ea = x_big ? ex : ey;
  assign eb = x_big ? ey : ex;
  assign ma = x_big ? mx : my;
  assign mb = x_big ? my : mx;

  assign ma_e = {ma, 3'b000};
  assign mb_e = {mb, 3'b000};
  assign amt  = ea - eb;

  fpadd_sticky_shr #(.N(EXT_W), .AW(XE_W)) u_align (.din(mb_e), .amt(amt), .dout(mb_al));

  assign tot = {1'b0, ma_e} + {1'b0, mb_al};
  assign dif = ma_e - mb_al;

  fpadd_lzc #(.N(EXT_W), .CW(LZ_W)) u_lzc (.vec(dif), .count(lzn));

  always_comb begin
    s_out    = sa;
    zero_out = 1'b0;
    carry    = 1'b0;
    if (sa == sb) begin
      carry = tot[EXT_W];
      if (carry) begin
        m_out = {tot[EXT_W:2], tot[1] | tot[0]};
        e_out = ea + XE_W'(1);
      end else begin
        m_out = tot[EXT_W-1:0];
        e_out = ea;
      end
    end else begin
      zero_out = (dif == '0);
      m_out    = dif << lzn;
      e_out    = ea - XE_W'(lzn);
    end
  end
endmodule

// File: rtl/fpadd_round.sv
`timescale 1ns/1ps
module fpadd_round import fpadd_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int XE_W  = 12
) (
  input  logic                   sign,
  input  logic signed [XE_W-1:0] exp_in,
  input  logic [MAN_W+3:0]       mant_ext,
  input  logic                   is_zero,
  input  logic [1:0]             rmode,
  output logic [EXP_W+MAN_W:0]   result,
  output logic                   overflow,
  output logic                   underflow,
  output logic                   inexact
);
  localparam int SIG_W = MAN_W + 1;
  localparam int EXT_W = SIG_W + 3;
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam logic signed [XE_W-1:0] EXP_TOP = XE_W'((1 << EXP_W) - 1);

  logic                   tiny, lost, inc, to_inf, carry;
  logic [XE_W-1:0]        sh_amt;
  logic [EXT_W-1:0]       m_tiny, m2;
  logic [SIG_W-1:0]       keep;
  logic [SIG_W:0]         rnd;
  logic signed [XE_W-1:0] e_fin;
  logic [MAN_W-1:0]       mant;

  assign tiny   = exp_in < $signed(XE_W'(1));
  assign sh_amt = XE_W'(1) - exp_in;

  fpadd_sticky_shr #(.N(EXT_W), .AW(XE_W)) u_denorm (.din(mant_ext), .amt(sh_amt), .dout(m_tiny));

  assign m2   = tiny ? m_tiny : mant_ext;
  assign keep = m2[EXT_W-1:3];
  assign lost = |m2[2:0];

  always_comb begin
    case (rmode)
      RM_NEAR: inc = m2[2] & (m2[1] | m2[0] | keep[0]);
      RM_ZERO: inc = 1'b0;
      RM_POS:  inc = ~sign & lost;
      default: inc = sign & lost;
    endcase
  end

  assign rnd   = {1'b0, keep} + {{SIG_W{1'b0}}, inc};
  assign carry = rnd[SIG_W];

  always_comb begin
    if (tiny)       e_fin = rnd[SIG_W-1] ? XE_W'(1) : XE_W'(0);
    else if (carry) e_fin = exp_in + XE_W'(1);
    else            e_fin = exp_in;
    mant = carry ? rnd[MAN_W:1] : rnd[MAN_W-1:0];
  end

  assign to_inf = (rmode == RM_NEAR) || (rmode == RM_POS && !sign) || (rmode == RM_NEG && sign);

  always_comb begin
    overflow  = 1'b0;
    underflow = 1'b0;
    inexact   = 1'b0;
    if (is_zero) begin
      result = {(rmode == RM_NEG), {(W-1){1'b0}}};
    end else if (!tiny && (e_fin >= EXP_TOP)) begin
      overflow = 1'b1;
      inexact  = 1'b1;
      result   = to_inf ? {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}}
                        : {sign, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
    end else begin
      inexact   = lost;
      underflow = tiny & lost;
      result    = {sign, e_fin[EXP_W-1:0], mant};
    end
  end
endmodule

// File: rtl/fpadd_sp.sv
`timescale 1ns/1ps
module fpadd_sp import fpadd_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [EXP_W+MAN_W:0]   op_a,
  input  logic [EXP_W+MAN_W:0]   op_b,
  input  logic [1:0]             round_mode,
  input  logic                   flush_dnorm,
  output logic [EXP_W+MAN_W:0]   sum_q,
  output logic                   invalid_q,
  output logic                   overflow_q,
  output logic                   underflow_q,
  output logic                   inexact_q
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int XE_W  = EXP_W + $clog2(MAN_W + 4) + 2;
  localparam int NOPS  = 2;

  logic [W-1:0]           ops   [NOPS];
  fp_class_e              cls   [NOPS];
  logic                   sgn   [NOPS];
  logic signed [XE_W-1:0] expu  [NOPS];
  logic [MAN_W:0]         sig   [NOPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_unpack
    fpadd_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XE_W(XE_W)) u_unpack (
      .op(ops[g]), .flush(flush_dnorm), .cls(cls[g]), .sign(sgn[g]),
      .exp_u(expu[g]), .sig(sig[g]));
  end

  // named events for the checker
  logic                   special_hit, special_inv, exact_cancel;
  logic [W-1:0]           special_res;
  logic                   core_sign, core_zero;
  logic signed [XE_W-1:0] core_exp;
  logic [MAN_W+3:0]       core_mant;
  logic [W-1:0]           rnd_res;
  logic                   rnd_ovf, rnd_unf, rnd_inx;

  fpadd_special #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_special (
    .cls_x(cls[0]), .cls_y(cls[1]), .op_x(op_a), .op_y(op_b), .rmode(round_mode),
    .hit(special_hit), .result(special_res), .invalid(special_inv));

  fpadd_align_add #(.MAN_W(MAN_W), .XE_W(XE_W)) u_core (
    .sx(sgn[0]), .ex(expu[0]), .mx(sig[0]), .sy(sgn[1]), .ey(expu[1]), .my(sig[1]),
    .s_out(core_sign), .e_out(core_exp), .m_out(core_mant), .zero_out(core_zero));

  fpadd_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XE_W(XE_W)) u_round (
    .sign(core_sign), .exp_in(core_exp), .mant_ext(core_mant), .is_zero(core_zero),
    .rmode(round_mode), .result(rnd_res), .overflow(rnd_ovf), .underflow(rnd_unf),
    .inexact(rnd_inx));

  assign exact_cancel = core_zero & ~special_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q       <= '0;
      invalid_q   <= 1'b0;
      overflow_q  <= 1'b0;
      underflow_q <= 1'b0;
      inexact_q   <= 1'b0;
    end else if (special_hit) begin
      sum_q       <= special_res;
      invalid_q   <= special_inv;
      overflow_q  <= 1'b0;
      underflow_q <= 1'b0;
      inexact_q   <= 1'b0;
    end else begin
      sum_q       <= rnd_res;
      invalid_q   <= 1'b0;
      overflow_q  <= rnd_ovf;
      underflow_q <= rnd_unf;
      inexact_q   <= rnd_inx;
    end
  end
endmodule

// File: rtl/fpadd_sp_chk.sv
`timescale 1ns/1ps
module fpadd_sp_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [EXP_W+MAN_W:0] op_a,
  input logic [EXP_W+MAN_W:0] op_b,
  input logic [1:0]           round_mode,
  input logic [EXP_W+MAN_W:0] sum_q,
  input logic                 invalid_q,
  input logic                 overflow_q,
  input logic                 underflow_q,
  input logic                 inexact_q,
  input logic                 exact_cancel
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic a_snan, b_snan, out_nan;
  assign a_snan  = (&op_a[W-2:MAN_W]) && (|op_a[MAN_W-1:0]) && !op_a[MAN_W-1];
  assign b_snan  = (&op_b[W-2:MAN_W]) && (|op_b[MAN_W-1:0]) && !op_b[MAN_W-1];
  assign out_nan = (&sum_q[W-2:MAN_W]) && (|sum_q[MAN_W-1:0]);

  AST_SNAN_RAISES_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (a_snan || b_snan) |=> invalid_q); // R2

  AST_NAN_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_nan |-> sum_q[MAN_W-1]); // R3

  AST_INVALID_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_q |-> (out_nan && !overflow_q && !underflow_q && !inexact_q)); // R4

  AST_CANCEL_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    exact_cancel |=> (sum_q == {($past(round_mode) == 2'd3), {(W-1){1'b0}}}) && !inexact_q); // R7

  AST_OVERFLOW_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_q |-> inexact_q); // R9

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !underflow_q); // R10
endmodule

bind fpadd_sp fpadd_sp_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .round_mode(round_mode),
  .sum_q(sum_q), .invalid_q(invalid_q), .overflow_q(overflow_q),
  .underflow_q(underflow_q), .inexact_q(inexact_q), .exact_cancel(exact_cancel));

// File: tb/tb_fpadd_sp.sv
`timescale 1ns/1ps
module tb_fpadd_sp;
  localparam int EW = 4;
  localparam int MW = 3;
  localparam int W  = 1 + EW + MW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [1:0]   rm = 2'd0;
  logic         fl = 1'b0;
  logic [W-1:0] sum_q;
  logic         invalid_q, overflow_q, underflow_q, inexact_q;

  int checks = 0;
  int errors = 0;
  int unf_seen = 0;

  always #10 clk = ~clk;

  fpadd_sp #(.EXP_W(EW), .MAN_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .round_mode(rm), .flush_dnorm(fl),
    .sum_q(sum_q), .invalid_q(invalid_q), .overflow_q(overflow_q),
    .underflow_q(underflow_q), .inexact_q(inexact_q));

  // values in units of the smallest subnormal, 2^-9 for this format
  function automatic int unit_val(input logic [7:0] x);
    if (x[6:3] == 4'd0) return int'(x[2:0]);
    return (8 + int'(x[2:0])) << (int'(x[6:3]) - 1);
  endfunction

  function automatic void model(input logic [7:0] x, input logic [7:0] y, input logic [1:0] m,
                                input logic f, output logic [7:0] r, output logic [3:0] fg,
                                output string tag);
    logic xn, yn, xs, ys, xi, yi, xz, yz, sg;
    int s, mag, p, k, q, rem, half, e;
    logic up;
    xn = (x[6:3] == 4'hF) && (x[2:0] != 0);
    yn = (y[6:3] == 4'hF) && (y[2:0] != 0);
    xs = xn && !x[2];
    ys = yn && !y[2];
    xi = (x[6:3] == 4'hF) && (x[2:0] == 0);
    yi = (y[6:3] == 4'hF) && (y[2:0] == 0);
    xz = (x[6:3] == 0) && ((x[2:0] == 0) || f);
    yz = (y[6:3] == 0) && ((y[2:0] == 0) || f);
    fg = 4'b0000;
    tag = "R6";
    if (xs) begin r = x | 8'h04; fg = 4'b1000; tag = "R2"; end
    else if (ys) begin r = y | 8'h04; fg = 4'b1000; tag = "R2"; end
    else if (xn) begin r = x; tag = "R3"; end
    else if (yn) begin r = y; tag = "R3"; end
    else if (xi && yi) begin
      tag = "R4";
      if (x[7] == y[7]) r = x;
      else begin r = 8'h7C; fg = 4'b1000; end
    end
    else if (xi) begin r = x; tag = "R4"; end
    else if (yi) begin r = y; tag = "R4"; end
    else if (xz && yz) begin
      r = {(x[7] == y[7]) ? x[7] : (m == 2'd3), 7'd0};
      tag = f ? "R1" : "R5";
    end
    else if (xz) begin r = y; tag = "R5"; end
    else if (yz) begin r = x; tag = "R5"; end
    else begin
      s = (x[7] ? -unit_val(x) : unit_val(x)) + (y[7] ? -unit_val(y) : unit_val(y));
      if (s == 0) begin
        r = {(m == 2'd3), 7'd0};
        tag = "R7";
      end else begin
        sg  = (s < 0);
        mag = sg ? -s : s;
        if (mag < 16) begin
          r = {sg, 7'(mag)};
          tag = "R10";
        end else begin
          p = 0;
          while ((mag >> (p + 1)) != 0) p++;
          k    = p - 3;
          q    = mag >> k;
          rem  = mag - (q << k);
          half = 1 << (k - 1);
          case (m)
            2'd0:    up = (rem > half) || ((rem == half) && q[0]);
            2'd1:    up = 1'b0;
            2'd2:    up = !sg && (rem != 0);
            default: up = sg && (rem != 0);
          endcase
          if (up) q++;
          if (q == 16) begin q = 8; k++; end
          e = k + 1;
          if (e >= 15) begin
            tag = "R9";
            fg  = 4'b0101;
            if (m == 2'd0 || (m == 2'd2 && !sg) || (m == 2'd3 && sg)) r = {sg, 7'h78};
            else r = {sg, 7'h77};
          end else begin
            r = {sg, 4'(e), 3'(q)};
            if (rem != 0) begin fg = 4'b0001; tag = "R8"; end
          end
        end
      end
    end
  endfunction

  task automatic report(input string tag, input logic [7:0] ga, input logic [7:0] gb,
                        input logic [7:0] er, input logic [3:0] ef);
    checks++;
    if (sum_q !== er || {invalid_q, overflow_q, underflow_q, inexact_q} !== ef) begin
      errors++;
      $display("FAIL %s a=%h b=%h rm=%0d fl=%0b actual %h/%b expected %h/%b", tag, ga, gb,
               rm, fl, sum_q, {invalid_q, overflow_q, underflow_q, inexact_q}, er, ef);
    end
  endtask

  task automatic run_vec(input logic [7:0] va, input logic [7:0] vb, input logic [1:0] vrm,
                         input logic vfl);
    logic [7:0] er;
    logic [3:0] ef;
    string tg;
    a = va; b = vb; rm = vrm; fl = vfl;
    model(va, vb, vrm, vfl, er, ef, tg);
    @(posedge clk); #2;
    if (underflow_q) unf_seen++;
    report(tg, va, vb, er, ef);
  endtask

  task automatic dir(input string tag, input logic [7:0] va, input logic [7:0] vb,
                     input logic [1:0] vrm, input logic vfl, input logic [7:0] er,
                     input logic [3:0] ef);
    a = va; b = vb; rm = vrm; fl = vfl;
    @(posedge clk); #2;
    report(tag, va, vb, er, ef);
  endtask

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: outputs held at zero during reset
    a = 8'h38; b = 8'h38;
    repeat (3) @(posedge clk);
    #2;
    report("R11", a, b, 8'h00, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: one-edge latency; result holds until the next edge
    dir("R11", 8'h38, 8'h38, 2'd0, 1'b0, 8'h40, 4'b0000);
    a = 8'h78; b = 8'hF8; #1;
    report("R11", a, b, 8'h40, 4'b0000);

    dir("R1", 8'h01, 8'h01, 2'd0, 1'b0, 8'h02, 4'b0000);
    dir("R1", 8'h01, 8'h01, 2'd0, 1'b1, 8'h00, 4'b0000);
    dir("R1", 8'h81, 8'h01, 2'd3, 1'b1, 8'h80, 4'b0000);
    dir("R2", 8'h79, 8'h7A, 2'd0, 1'b0, 8'h7D, 4'b1000);
    dir("R2", 8'h7E, 8'hFA, 2'd0, 1'b0, 8'hFE, 4'b1000);
    dir("R3", 8'h7E, 8'hFD, 2'd0, 1'b0, 8'h7E, 4'b0000);
    dir("R3", 8'h38, 8'hFD, 2'd1, 1'b0, 8'hFD, 4'b0000);
    dir("R4", 8'h78, 8'hF8, 2'd0, 1'b0, 8'h7C, 4'b1000);
    dir("R4", 8'h78, 8'h38, 2'd2, 1'b0, 8'h78, 4'b0000);
    dir("R4", 8'hF8, 8'hF8, 2'd0, 1'b0, 8'hF8, 4'b0000);
    dir("R5", 8'h80, 8'h80, 2'd0, 1'b0, 8'h80, 4'b0000);
    dir("R5", 8'h00, 8'h80, 2'd3, 1'b0, 8'h80, 4'b0000);
    dir("R5", 8'h00, 8'h80, 2'd0, 1'b0, 8'h00, 4'b0000);
    dir("R5", 8'h80, 8'h05, 2'd0, 1'b0, 8'h05, 4'b0000);
    dir("R6", 8'h38, 8'h20, 2'd0, 1'b0, 8'h39, 4'b0000);
    dir("R6", 8'h38, 8'h18, 2'd0, 1'b0, 8'h38, 4'b0001);
    dir("R6", 8'h39, 8'h18, 2'd0, 1'b0, 8'h3A, 4'b0001);
    dir("R6", 8'h3F, 8'h3F, 2'd0, 1'b0, 8'h47, 4'b0000);
    dir("R6", 8'h3F, 8'h18, 2'd0, 1'b0, 8'h40, 4'b0001);
    dir("R7", 8'h38, 8'hB8, 2'd0, 1'b0, 8'h00, 4'b0000);
    dir("R7", 8'h38, 8'hB8, 2'd3, 1'b0, 8'h80, 4'b0000);
    dir("R8", 8'h38, 8'h01, 2'd2, 1'b0, 8'h39, 4'b0001);
    dir("R8", 8'h38, 8'h01, 2'd1, 1'b0, 8'h38, 4'b0001);
    dir("R9", 8'h77, 8'h77, 2'd0, 1'b0, 8'h78, 4'b0101);
    dir("R9", 8'h77, 8'h77, 2'd1, 1'b0, 8'h77, 4'b0101);
    dir("R9", 8'h77, 8'h77, 2'd3, 1'b0, 8'h77, 4'b0101);
    dir("R9", 8'hF7, 8'hF7, 2'd3, 1'b0, 8'hF8, 4'b0101);
    dir("R9", 8'hF7, 8'hF7, 2'd2, 1'b0, 8'hF7, 4'b0101);
    dir("R10", 8'h09, 8'h88, 2'd0, 1'b0, 8'h01, 4'b0000);

    // exhaustive sweep over every pair, modes and flush rotating
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        run_vec(8'(i), 8'(j), 2'(i + 3 * j), 1'((i >> 2) ^ j));
      end
    end

    checks++;
    if (unf_seen != 0) begin
      errors++;
      $display("FAIL R10 underflow cycles actual %0d expected 0", unf_seen);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule